// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable, cycle-accurate model of a 32-bit synchronous pipelined burst SRAM. It is meant to stand in for an external cache memory in system simulation. Address, chip selects and write controls are sampled on the rising clock edge. An access is opened by either of two address strobes: a processor strobe that always begins as a read, and a controller strobe that can read or write at once. A two-bit burst counter then walks the four words of an aligned group in linear or interleaved order. Read data leaves through an output register.

The shared data bus is split into `wdata`, `rdata` and a drive enable `rdata_oe`. The enable combines the registered read state with an asynchronous output-enable input. It is forced low whenever write controls are asserted or the sleep input is high. After sleep ends, the strobes are ignored for two clock edges. Array depth is a parameter, so simulations stay small.

Top module: `sync_burst_sram`

## Requirements
- R1: A read accepted at a rising edge puts the addressed word on `rdata`, with `rdata_oe` high when `out_en_n` is low, right after that same edge. The word is held in an output register.
- R2: A strobe accepted while selected (`en_a_n`=0, `en_b`=1, `en_c_n`=0) latches `addr`. Burst step 0 accesses `addr` itself.
- R3: `cpu_strobe_n` is ignored while `en_a_n` is high. When both strobes are low and `cpu_strobe_n` is not ignored, the processor strobe wins.
- R4: An access started by `cpu_strobe_n` is always a read, whatever the write inputs. Write data is taken only on the following clocks, at the burst address.
- R5: Lane i is bits 8i+7:8i. With `lane_wr_en_n`=0, the lanes whose `lane_sel_n[i]`=0 are written and the other lanes keep their contents.
- R6: `all_wr_n`=0 writes all four lanes. If no lane is enabled, the cycle is a read.
- R7: Burst offsets come from the start offset b (addr[1:0]) and the step k. With `seq_linear`=1 the offset is (b+k) mod 4; with `seq_linear`=0 it is b XOR k. A non-strobe edge with `adv_n`=0 increments k, wrapping mod 4.
- R8: A non-strobe edge with `adv_n`=1 repeats the current burst address.
- R9: `rdata_oe` is low during any cycle whose write inputs enable a lane, regardless of `out_en_n`. It stays low after a write edge.
- R10: `out_en_n` acts on `rdata_oe` without a clock edge.
- R11: While `sleep` is high the bus is released and no access occurs. The first two rising edges after `sleep` falls ignore both strobes, and the bus is released on wake.
- R12: A strobe accepted while deselected ends the burst. `rdata_oe` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW | Word address, AW = log2(DEPTH) |
| en_a_n | input | 1 | Primary chip select, active low; also gates the processor strobe |
| en_b | input | 1 | Chip select, active high |
| en_c_n | input | 1 | Chip select, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Byte-lane write qualifier, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| seq_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| wdata | input | 32 | Write data from the bus |
| rdata | output | 32 | Registered read data |
| rdata_oe | output | 1 | Bus drive enable for rdata |

## Verification
Read data and its enable are due right after the edge that accepts the access. The bench therefore samples at the falling edge that follows each rising edge. `out_en_n`, write-control and sleep effects on `rdata_oe` are due with no edge at all. Each cycle is therefore checked a second time 1 ns after the inputs change at the falling edge. Recovery after sleep is due on the third edge following its fall. A behavioural reference model updated on every rising edge gives the expected bus values for both sample points.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   localparam int BURST_W = 2;

   // offset inside the aligned group for a burst step
   function automatic logic [BURST_W-1:0] burst_offset(
      input logic [BURST_W-1:0] start,
      input logic [BURST_W-1:0] step,
      input logic               linear);
      return linear ? (start + step) : (start ^ step);
   endfunction
endpackage

// File: rtl/sbs_lane_dec.sv
module sbs_lane_dec #(
   parameter int LANES = 4
) (
   input  logic             all_wr_n,
   input  logic             lane_wr_en_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic [LANES-1:0] lanes,
   output logic             wr_req
);
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("sbs_lane_dec: LANES must be at least 1");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lanes[g] = ~all_wr_n | (~lane_wr_en_n & ~lane_sel_n[g]);
      end
   endgenerate

   assign wr_req = |lanes;
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
   import sbs_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          en_a_n,
   input  logic          en_b,
   input  logic          en_c_n,
   input  logic          cpu_strobe_n,
   input  logic          ctl_strobe_n,
   input  logic          adv_n,
   input  logic          sleep,
   input  logic          seq_linear,
   input  logic          wr_req,
   output logic          do_rd,
   output logic          do_wr,
   output logic [AW-1:0] acc_addr
);
   localparam int REC_CYC = 2;
   localparam int REC_W   = $clog2(REC_CYC + 1);

   generate
      if (AW < BURST_W) begin : g_bad_aw
         $error("sbs_ctrl: address narrower than burst counter");
      end
   endgenerate

   logic               active_q, active_d;
   logic [AW-1:0]      base_q, base_d;
   logic [BURST_W-1:0] step_q, step_d;
   logic [REC_W-1:0]   rec_q, rec_d;
   logic               awake, selected, cpu_go, ctl_go;

   assign awake    = ~sleep && (rec_q == '0);
   assign selected = ~en_a_n && en_b && ~en_c_n;
   assign cpu_go   = awake && ~cpu_strobe_n && ~en_a_n;
   assign ctl_go   = awake && ~cpu_go && ~ctl_strobe_n;

   always_comb begin
      active_d = active_q;
      base_d   = base_q;
      step_d   = step_q;
      do_rd    = 1'b0;
      do_wr    = 1'b0;
      rec_d    = sleep ? REC_W'(REC_CYC) : ((rec_q != '0) ? rec_q - 1'b1 : '0);
      if (sleep) begin
         active_d = 1'b0;
      end else if (cpu_go || ctl_go) begin
         active_d = selected;
         if (selected) begin
            base_d = addr;
            step_d = '0;
            do_wr  = ctl_go && wr_req;
            do_rd  = ~(ctl_go && wr_req);
         end
      end else if (awake && active_q) begin
         if (!adv_n) step_d = step_q + 1'b1;
         do_wr = wr_req;
         do_rd = ~wr_req;
      end
      acc_addr = {base_d[AW-1:BURST_W],
                  burst_offset(base_d[BURST_W-1:0], step_d, seq_linear)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         base_q   <= '0;
         step_q   <= '0;
         rec_q    <= '0;
      end else begin
         active_q <= active_d;
         base_q   <= base_d;
         step_q   <= step_d;
         rec_q    <= rec_d;
      end
   end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
   parameter int DEPTH  = 64,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    do_rd,
   input  logic                    do_wr,
   input  logic [AW-1:0]           addr,
   input  logic [LANES-1:0]        lanes,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rd_valid
);
   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sbs_array: DEPTH must be a power of two, at least 4");
      end
      if (LANE_W < 1) begin : g_bad_width
         $error("sbs_array: LANE_W must be positive");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] store [DEPTH];
         logic [LANE_W-1:0] out_q;
         always_ff @(posedge clk) begin
            if (do_wr && lanes[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
            if (do_rd) out_q <= store[addr];
         end
         assign rdata[g*LANE_W +: LANE_W] = out_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= do_rd;
   end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
   parameter int DEPTH  = 64,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int AW     = $clog2(DEPTH),
   parameter int DW     = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             en_a_n,
   input  logic             en_b,
   input  logic             en_c_n,
   input  logic             cpu_strobe_n,
   input  logic             ctl_strobe_n,
   input  logic             adv_n,
   input  logic             all_wr_n,
   input  logic             lane_wr_en_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             out_en_n,
   input  logic             sleep,
   input  logic             seq_linear,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   output logic             rdata_oe
);
   logic [LANES-1:0] lanes;
   logic             wr_req, do_rd, do_wr, rd_valid;
   logic [AW-1:0]    acc_addr;

   sbs_lane_dec #(.LANES(LANES)) u_dec (
      .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
      .lanes(lanes), .wr_req(wr_req));

   sbs_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
      .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .adv_n(adv_n),
      .sleep(sleep), .seq_linear(seq_linear), .wr_req(wr_req),
      .do_rd(do_rd), .do_wr(do_wr), .acc_addr(acc_addr));

   sbs_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_array (
      .clk(clk), .rst_n(rst_n), .do_rd(do_rd), .do_wr(do_wr), .addr(acc_addr),
      .lanes(lanes), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid));

   // drive only with a held read word, enable low, awake and no write pending
   assign rdata_oe = rd_valid & ~out_en_n & ~sleep & ~wr_req;
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk (
   input logic clk,
   input logic rst_n,
   input logic sleep,
   input logic cpu_strobe_n,
   input logic ctl_strobe_n,
   input logic en_a_n,
   input logic en_b,
   input logic out_en_n,
   input logic rdata_oe,
   input logic do_rd,
   input logic do_wr
);
   a_r5_single_op: assert property (@(posedge clk) disable iff (!rst_n)
      !(do_rd && do_wr));

   a_r4_cpu_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_strobe_n && !en_a_n) |-> !do_wr);

   a_r10_drive_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (!out_en_n && !sleep));

   a_r11_wake_released: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep) |-> !rdata_oe);

   a_r11_recovery_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sleep) || $past(sleep, 2)) |-> !(do_rd || do_wr));

   a_r12_deselect_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_strobe_n && !ctl_strobe_n && !en_b && !sleep) |=> !rdata_oe);
endmodule

bind sync_burst_sram sbs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sleep(sleep), .cpu_strobe_n(cpu_strobe_n),
   .ctl_strobe_n(ctl_strobe_n), .en_a_n(en_a_n), .en_b(en_b),
   .out_en_n(out_en_n), .rdata_oe(rdata_oe), .do_rd(do_rd), .do_wr(do_wr));

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;
   localparam int DEPTH = 64;
   localparam int AW    = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
   logic          cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, adv_n = 1'b1;
   logic          all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
   logic [3:0]    lane_sel_n = 4'hF;
   logic          out_en_n = 1'b0, sleep = 1'b0, seq_linear = 1'b1;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          rdata_oe;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   sync_burst_sram #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .en_a_n(en_a_n), .en_b(en_b),
      .en_c_n(en_c_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
      .adv_n(adv_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
      .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .sleep(sleep),
      .seq_linear(seq_linear), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe));

   // ---------------- reference model ----------------
   logic [31:0] m_mem [DEPTH];
   bit          m_active, m_rdv;
   int          m_base, m_step, m_rec;
   logic [31:0] m_word;

   function automatic logic [3:0] lane_mask();
      if (!all_wr_n) return 4'hF;
      if (!lane_wr_en_n) return ~lane_sel_n;
      return 4'h0;
   endfunction

   function automatic logic [31:0] pat(input int a);
      return 32'h9E3779B9 * (a + 1);
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         logic [3:0] mk;
         bit awake, sel, rd, wr;
         int a;
         mk = lane_mask();
         awake = !sleep && m_rec == 0;
         sel = !en_a_n && en_b && !en_c_n;
         rd = 0; wr = 0; a = 0;
         if (sleep) m_rec = 2; else if (m_rec > 0) m_rec = m_rec - 1;
         if (sleep) m_active = 0;
         else if (awake) begin
            if (!cpu_strobe_n && !en_a_n) begin
               m_active = sel;
               if (sel) begin m_base = int'(addr); m_step = 0; a = m_base; rd = 1; end
            end else if (!ctl_strobe_n) begin
               m_active = sel;
               if (sel) begin
                  m_base = int'(addr); m_step = 0; a = m_base;
                  if (mk != 0) wr = 1; else rd = 1;
               end
            end else if (m_active) begin
               int off;
               if (!adv_n) m_step = (m_step + 1) % 4;
               off = seq_linear ? (m_base % 4 + m_step) % 4 : ((m_base % 4) ^ m_step);
               a = (m_base / 4) * 4 + off;
               if (mk != 0) wr = 1; else rd = 1;
            end
         end
         if (wr) for (int i = 0; i < 4; i++)
            if (mk[i]) m_mem[a][i*8 +: 8] = wdata[i*8 +: 8];
         m_rdv = rd;
         if (rd) m_word = m_mem[a];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cmp(input string tag);
      bit eo;
      eo = m_rdv && !out_en_n && !sleep && (lane_mask() == 0);
      chk({tag, " oe"}, {31'b0, rdata_oe}, {31'b0, eo});
      if (eo) chk({tag, " data"}, rdata, m_word);
   endtask

   task automatic cyc(input string tag);
      #1 cmp(tag);
      @(negedge clk);
      cmp(tag);
   endtask

   task automatic idle();
      cpu_strobe_n = 1; ctl_strobe_n = 1; adv_n = 1; all_wr_n = 1;
      lane_wr_en_n = 1; lane_sel_n = 4'hF; en_a_n = 0; en_b = 1; en_c_n = 0;
      out_en_n = 0; sleep = 0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] ex;
      int lin_seq [4] = '{5, 6, 7, 4};
      int int_seq [4] = '{6, 7, 4, 5};
      m_active = 0; m_rdv = 0; m_rec = 0; m_base = 0; m_step = 0; m_word = 0;
      repeat (3) @(negedge clk);
      chk("R1 reset oe", {31'b0, rdata_oe}, 32'd0);
      rst_n = 1;

      // R6: preload every word with a global write through the controller strobe
      for (int a = 0; a < DEPTH; a++) begin
         idle(); ctl_strobe_n = 0; addr = AW'(a); all_wr_n = 0; wdata = pat(a);
         cyc("R6 preload");
      end

      // R1 R2 R7: linear burst from offset 1
      idle(); seq_linear = 1; ctl_strobe_n = 0; addr = 5; cyc("R1 read");
      chk("R1 R2 first word", rdata, pat(5));
      chk("R1 oe after edge", {31'b0, rdata_oe}, 32'd1);
      for (int k = 1; k < 4; k++) begin
         idle(); adv_n = 0; cyc("R7 linear");
         chk("R7 linear order", rdata, pat(lin_seq[k]));
      end
      idle(); cyc("R8 suspend");
      chk("R8 suspend repeats", rdata, pat(4));

      // R10: asynchronous output enable
      out_en_n = 1; #1 chk("R10 oe off no clock", {31'b0, rdata_oe}, 32'd0);
      out_en_n = 0; #1 chk("R10 oe on no clock", {31'b0, rdata_oe}, 32'd1);
      @(negedge clk);

      // R7: interleaved burst from offset 2 via processor strobe
      idle(); seq_linear = 0; cpu_strobe_n = 0; addr = 6; cyc("R7 start");
      chk("R7 interleaved start", rdata, pat(6));
      for (int k = 1; k < 4; k++) begin
         idle(); seq_linear = 0; adv_n = 0; cyc("R7 interleaved");
         chk("R7 interleaved order", rdata, pat(int_seq[k]));
      end
      idle(); seq_linear = 0; adv_n = 0; cyc("R7 wrap");
      chk("R7 interleaved wrap", rdata, pat(6));
      seq_linear = 1;

      // R4 R5: processor strobe ignores write inputs, lane write on next clock
      idle(); cpu_strobe_n = 0; addr = 20; all_wr_n = 0; wdata = 32'hDEADBEEF;
      cyc("R4 strobe cycle");
      idle(); lane_wr_en_n = 0; lane_sel_n = 4'b1010; wdata = 32'h11223344;
      #1 chk("R9 oe off during write", {31'b0, rdata_oe}, 32'd0);
      cyc("R5 lane write");
      chk("R9 oe off after write", {31'b0, rdata_oe}, 32'd0);
      idle(); ctl_strobe_n = 0; addr = 20; cyc("R5 readback");
      ex = (pat(20) & 32'hFF00FF00) | (32'h11223344 & 32'h00FF00FF);
      chk("R4 R5 masked lanes", rdata, ex);

      // R3: priority of processor strobe and masking by en_a_n
      idle(); cpu_strobe_n = 0; ctl_strobe_n = 0; addr = 21; all_wr_n = 0;
      wdata = 32'h0BADF00D; cyc("R3 priority");
      chk("R3 cpu wins as read", rdata, pat(21));
      idle(); ctl_strobe_n = 0; addr = 8; cyc("R3 setup");
      idle(); en_a_n = 1; cpu_strobe_n = 0; addr = 12; cyc("R3 masked");
      chk("R3 masked strobe keeps burst", rdata, pat(8));

      // R6: global write, lane selects irrelevant
      idle(); ctl_strobe_n = 0; addr = 24; all_wr_n = 0; wdata = 32'hCAFE0001;
      cyc("R6 global");
      idle(); ctl_strobe_n = 0; addr = 24; cyc("R6 readback");
      chk("R6 all lanes", rdata, 32'hCAFE0001);

      // R12: deselect through strobe
      idle(); ctl_strobe_n = 0; en_b = 0; cyc("R12 deselect");
      chk("R12 bus off", {31'b0, rdata_oe}, 32'd0);

      // R11: sleep and two recovery edges
      idle(); sleep = 1; cyc("R11 sleep"); cyc("R11 sleep");
      idle(); ctl_strobe_n = 0; addr = 30; cyc("R11 rec1");
      chk("R11 ignored edge 1", {31'b0, rdata_oe}, 32'd0);
      cyc("R11 rec2");
      chk("R11 ignored edge 2", {31'b0, rdata_oe}, 32'd0);
      cyc("R11 rec3");
      chk("R11 accepted edge 3", rdata, pat(30));
      chk("R11 oe after recovery", {31'b0, rdata_oe}, 32'd1);

      // mixed stimulus against the model
      for (int n = 0; n < 3000; n++) begin
         idle();
         cpu_strobe_n = ($urandom % 100) >= 15;
         ctl_strobe_n = ($urandom % 100) >= 20;
         adv_n = $urandom % 2;
         all_wr_n = ($urandom % 100) >= 8;
         lane_wr_en_n = ($urandom % 100) >= 25;
         lane_sel_n = 4'($urandom);
         en_a_n = ($urandom % 100) < 10;
         en_b = ($urandom % 100) >= 8;
         en_c_n = ($urandom % 100) < 5;
         out_en_n = ($urandom % 100) < 20;
         sleep = ($urandom % 100) < 3;
         seq_linear = $urandom % 2;
         addr = AW'($urandom);
         wdata = $urandom;
         cyc("R1 R3 R7 R9 R11 mixed");
      end
      finish_run();
   end
endmodule